// File: doc/BRIEF.md
# Gap-Coded Transponder Block Writer

This block writes one 32-bit block into a rewritable low-frequency transponder. It does this only by switching the reader's field on and off. A write request carries a 32-bit data word and a 3-bit block address. The block then runs the whole write on its own:

1. The field is held on so the antenna can settle and the tag can power up.
2. The field drops for a start gap.
3. A fixed 38-bit command frame is sent. Each bit is coded only by how long the field stays on, and each bit is followed by a fixed off-gap.
4. The field is held on for a programming period and then switched off.

Every duration is a parameter in microseconds. A clocks-per-microsecond parameter turns it into clock cycles. With the defaults, one clock is one microsecond.

Requests use a plain start/busy handshake. A start is taken only in a cycle where `busy` is low. Nothing is queued: a start seen while `busy` is high is dropped and has no later effect. When a request is taken, its data and address are captured, so the source may change them at once. `done` marks the first idle cycle after a write.

Top module: `gap_tag_writer`

## Requirements
- R1: After reset, `field_en`, `busy` and `done` are all 0.
- R2: A start taken while idle raises `busy` and `field_en` in the next cycle, and the field then stays on for exactly SETTLE_US×CLK_PER_US cycles.
- R3: After the settle period, the field is off for exactly START_GAP_US×CLK_PER_US cycles.
- R4: Each frame bit is an on-pulse of ZERO_US×CLK_PER_US cycles for a 0, or ONE_US×CLK_PER_US cycles for a 1. Every bit, including the last, is followed by an off-gap of exactly GAP_US×CLK_PER_US cycles.
- R5: The frame is 38 bits, sent in this order:
  - bit 1: opcode bit 1;
  - bit 2: opcode bit 0, which selects page zero;
  - bit 3: lock bit 0;
  - bits 4 to 35: data[31] down to data[0];
  - bits 36 to 38: block[2] down to block[0].
- R6: After the last gap, the field is on for exactly PROG_US×CLK_PER_US cycles, and is then switched off.
- R7: `busy` is high from the cycle after the start is taken until the programming hold ends. A start while `busy` is high is ignored.
- R8: `done` is high for exactly one cycle: the first cycle after the programming hold. In that cycle `busy` and `field_en` are 0.
- R9: `data` and `block` are captured when the start is taken. Changes to them during the write do not alter the frame.
- R10: A start held high through the `done` cycle is taken on that cycle. The next write then begins with no further idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Write request, taken only while `busy` is low |
| data | input | 32 | Block contents to write |
| block | input | 3 | Block address |
| field_en | output | 1 | Reader field enable (1 = carrier on) |
| busy | output | 1 | A write sequence is in progress |
| done | output | 1 | One-cycle pulse after the write completes |

## Verification
The writer is driven with an alternating-nibble data word, with all-zero and all-one words at block addresses 0 and 7, and with a word whose bits differ between neighbours. These show whether the short and long on-pulses are told apart, and whether the bit order is kept at both ends of the frame.

One run changes `data` and `block`, and pulses `start`, in the middle of a write. A wrong frame or a restarted sequence shows that capture or start filtering has failed.

Another run holds `start` high across the `done` cycle. This separates an immediate restart from a lost or delayed one.

The field output is also decoded back into on-runs and off-runs. This checks the phase lengths and the decoded frame without relying on the per-cycle model.

// File: rtl/gapwr_pkg.sv
package gapwr_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETTLE,
    PH_SGAP,
    PH_BON,
    PH_BGAP,
    PH_PROG
  } phase_e;

  // Opcode "10" (page zero) followed by lock bit 0, sent first.
  localparam logic [2:0] FRAME_HDR = 3'b100;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic logic phase_field_on(input phase_e p);
    return (p == PH_SETTLE) || (p == PH_BON) || (p == PH_PROG);
  endfunction

endpackage

// File: rtl/gapwr_frame.sv
module gapwr_frame
  import gapwr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3,
  parameter int FRAME_W = 3 + DATA_W + ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              shift,
  input  logic              busy,
  input  logic [DATA_W-1:0] data,
  input  logic [ADDR_W-1:0] block,
  output logic              cur_bit
);

  logic [FRAME_W-1:0] frame_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frame_q <= '0;
    end else if (load) begin
      frame_q <= {FRAME_HDR, data, block};
    end else if (shift) begin
      frame_q <= {frame_q[FRAME_W-2:0], 1'b0};
    end
  end

  assign cur_bit = frame_q[FRAME_W-1];

  // R9: a busy sequence never reloads the captured frame.
  p_no_reload_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !load);

endmodule

// File: rtl/gapwr_timer.sv
module gapwr_timer #(
  parameter int MAX_C = 150000,
  parameter int CW = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero = (cnt_q == '0);

  // R2: the phase counter never exceeds the longest phase.
  p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(MAX_C - 1));

  // R4: a counter that is not reloaded counts down by one.
  p_cnt_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !zero) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/gapwr_ctrl.sv
module gapwr_ctrl
  import gapwr_pkg::*;
#(
  parameter int CW = 18,
  parameter int FRAME_W = 38,
  parameter int SETTLE_C = 150000,
  parameter int SGAP_C = 250,
  parameter int ZERO_C = 144,
  parameter int ONE_C = 400,
  parameter int GAP_C = 160,
  parameter int PROG_C = 20000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          cur_bit,
  input  logic          tmr_zero,
  output logic          tmr_load,
  output logic [CW-1:0] tmr_val,
  output logic          frm_load,
  output logic          frm_shift,
  output logic          field_en,
  output logic          busy,
  output logic          done
);

  localparam int BW = $clog2(FRAME_W + 1);

  phase_e        ph_q, ph_d;
  logic [BW-1:0] sent_q;
  logic          done_q;

  always_comb begin
    ph_d      = ph_q;
    tmr_load  = 1'b0;
    tmr_val   = '0;
    frm_load  = 1'b0;
    frm_shift = 1'b0;
    unique case (ph_q)
      PH_IDLE: if (start) begin
        ph_d     = PH_SETTLE;
        tmr_load = 1'b1;
        tmr_val  = CW'(SETTLE_C - 1);
        frm_load = 1'b1;
      end
      PH_SETTLE: if (tmr_zero) begin
        ph_d     = PH_SGAP;
        tmr_load = 1'b1;
        tmr_val  = CW'(SGAP_C - 1);
      end
      PH_SGAP: if (tmr_zero) begin
        ph_d     = PH_BON;
        tmr_load = 1'b1;
        tmr_val  = cur_bit ? CW'(ONE_C - 1) : CW'(ZERO_C - 1);
      end
      PH_BON: if (tmr_zero) begin
        ph_d      = PH_BGAP;
        tmr_load  = 1'b1;
        tmr_val   = CW'(GAP_C - 1);
        frm_shift = 1'b1;
      end
      PH_BGAP: if (tmr_zero) begin
        tmr_load = 1'b1;
        if (sent_q == BW'(FRAME_W)) begin
          ph_d    = PH_PROG;
          tmr_val = CW'(PROG_C - 1);
        end else begin
          ph_d    = PH_BON;
          tmr_val = cur_bit ? CW'(ONE_C - 1) : CW'(ZERO_C - 1);
        end
      end
      PH_PROG: if (tmr_zero) begin
        ph_d = PH_IDLE;
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      sent_q <= '0;
      done_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      done_q <= (ph_q == PH_PROG) && tmr_zero;
      if (frm_load) begin
        sent_q <= '0;
      end else if (frm_shift) begin
        sent_q <= sent_q + 1'b1;
      end
    end
  end

  assign field_en = phase_field_on(ph_q);
  assign busy     = (ph_q != PH_IDLE);
  assign done     = done_q;

  // R8: done lasts exactly one cycle.
  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8: done follows a busy cycle and finds the block idle.
  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !field_en && $past(busy)));

  // R5: never more bits than the frame holds.
  p_bits_bounded_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sent_q <= BW'(FRAME_W));

  // R6: the programming hold starts only after the full frame.
  p_prog_after_frame_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_PROG) |-> (sent_q == BW'(FRAME_W)));

  // R7: a write started from idle raises busy and the field together.
  p_start_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> (busy && field_en));

endmodule

// File: rtl/gap_tag_writer.sv
module gap_tag_writer
  import gapwr_pkg::*;
#(
  parameter int CLK_PER_US = 1,
  parameter int SETTLE_US = 150000,
  parameter int START_GAP_US = 250,
  parameter int ZERO_US = 144,
  parameter int ONE_US = 400,
  parameter int GAP_US = 160,
  parameter int PROG_US = 20000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [31:0] data,
  input  logic [2:0]  block,
  output logic        field_en,
  output logic        busy,
  output logic        done
);

  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 3;
  localparam int FRAME_W  = 3 + DATA_W + ADDR_W;
  localparam int SETTLE_C = imax(1, SETTLE_US * CLK_PER_US);
  localparam int SGAP_C   = imax(1, START_GAP_US * CLK_PER_US);
  localparam int ZERO_C   = imax(1, ZERO_US * CLK_PER_US);
  localparam int ONE_C    = imax(1, ONE_US * CLK_PER_US);
  localparam int GAP_C    = imax(1, GAP_US * CLK_PER_US);
  localparam int PROG_C   = imax(1, PROG_US * CLK_PER_US);
  localparam int MAX_C    = imax(imax(imax(SETTLE_C, SGAP_C), imax(ZERO_C, ONE_C)),
                                 imax(GAP_C, PROG_C));
  localparam int CW       = imax(1, $clog2(MAX_C));

  logic          tmr_load, tmr_zero, frm_load, frm_shift, cur_bit;
  logic [CW-1:0] tmr_val;

  gapwr_ctrl #(
    .CW(CW), .FRAME_W(FRAME_W), .SETTLE_C(SETTLE_C), .SGAP_C(SGAP_C),
    .ZERO_C(ZERO_C), .ONE_C(ONE_C), .GAP_C(GAP_C), .PROG_C(PROG_C)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .cur_bit(cur_bit),
    .tmr_zero(tmr_zero), .tmr_load(tmr_load), .tmr_val(tmr_val),
    .frm_load(frm_load), .frm_shift(frm_shift), .field_en(field_en),
    .busy(busy), .done(done)
  );

  gapwr_timer #(.MAX_C(MAX_C), .CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
    .zero(tmr_zero)
  );

  gapwr_frame #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .FRAME_W(FRAME_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .load(frm_load), .shift(frm_shift),
    .busy(busy), .data(data), .block(block), .cur_bit(cur_bit)
  );

  // R3: the field never switches on in the cycle after a done.
  p_idle_after_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> !field_en);

endmodule

// File: tb/gap_tag_writer_test.sv
module gap_tag_writer_test;

  localparam int SETTLE = 20, SGAP = 5, ZERO = 3, ONE = 7, GAP = 2, PROG = 11;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] data = '0;
  logic [2:0]  block = '0;
  logic        field_en, busy, done;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  gap_tag_writer #(
    .CLK_PER_US(1), .SETTLE_US(SETTLE), .START_GAP_US(SGAP),
    .ZERO_US(ZERO), .ONE_US(ONE), .GAP_US(GAP), .PROG_US(PROG)
  ) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .data(data), .block(block),
    .field_en(field_en), .busy(busy), .done(done)
  );

  // Behavioural reference: queue of expected cycles, value = phase*2 + field.
  int          q[$];
  logic        m_field = 0, m_busy = 0, m_done = 0;
  int          m_phase = 0;
  logic [37:0] exp_frame;

  function automatic string tag_of(input int ph, input logic dn);
    if (dn) return "R8";
    case (ph)
      1: return "R2";
      2: return "R3";
      3, 4: return "R4";
      5: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic push_run(input int n, input int ph, input int fld);
    for (int k = 0; k < n; k++) q.push_back(ph * 2 + fld);
  endtask

  always @(posedge clk) begin
    int v;
    if (!rst_n) begin
      q.delete();
      m_field = 0; m_busy = 0; m_done = 0; m_phase = 0;
    end else if (!m_busy && start) begin
      exp_frame = {3'b100, data, block};
      push_run(SETTLE, 1, 1);
      push_run(SGAP, 2, 0);
      for (int i = 37; i >= 0; i--) begin
        push_run(exp_frame[i] ? ONE : ZERO, 3, 1);
        push_run(GAP, 4, 0);
      end
      push_run(PROG, 5, 1);
      v = q.pop_front();
      m_field = v[0]; m_phase = v / 2; m_busy = 1; m_done = 0;
    end else if (m_busy) begin
      if (q.size() > 0) begin
        v = q.pop_front();
        m_field = v[0]; m_phase = v / 2; m_done = 0;
      end else begin
        m_field = 0; m_busy = 0; m_done = 1; m_phase = 0;
      end
    end else begin
      m_done = 0; m_phase = 0;
    end
  end

  task automatic check(input string req, input logic ok, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Per-cycle comparison, sampled on the falling edge.
  always @(negedge clk) begin
    if (rst_n) begin
      check(tag_of(m_phase, m_done), {field_en, busy, done} == {m_field, m_busy, m_done},
            "field/busy/done", int'({field_en, busy, done}), int'({m_field, m_busy, m_done}));
    end
  end

  // Independent run-length decoder of field_en.
  int   on_runs[$];
  int   off_runs[$];
  int   run_len = 0;
  logic run_val = 0;
  logic prev_busy = 0;

  task automatic evaluate();
    logic [37:0] got;
    got = '0;
    check("R5", on_runs.size() == 40, "on-run count", on_runs.size(), 40);
    check("R4", off_runs.size() == 39, "off-run count", off_runs.size(), 39);
    if (on_runs.size() == 40 && off_runs.size() == 39) begin
      check("R2", on_runs[0] == SETTLE, "settle length", on_runs[0], SETTLE);
      check("R6", on_runs[39] == PROG, "prog length", on_runs[39], PROG);
      check("R3", off_runs[0] == SGAP, "start gap length", off_runs[0], SGAP);
      for (int i = 1; i < 39; i++) begin
        check("R4", off_runs[i] == GAP, "bit gap length", off_runs[i], GAP);
        check("R4", on_runs[i] == ONE || on_runs[i] == ZERO, "bit pulse length",
              on_runs[i], exp_frame[38 - i] ? ONE : ZERO);
        got[38 - i] = (on_runs[i] == ONE);
      end
      check("R5", got == exp_frame, "decoded frame low word",
            int'(got[31:0]), int'(exp_frame[31:0]));
      check("R9", got[37:32] == exp_frame[37:32], "decoded header/data high",
            int'(got[37:32]), int'(exp_frame[37:32]));
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      prev_busy = 0;
    end else begin
      if (busy && !prev_busy) begin
        on_runs.delete(); off_runs.delete();
        run_val = field_en; run_len = 1;
      end else if (busy) begin
        if (field_en == run_val) run_len++;
        else begin
          if (run_val) on_runs.push_back(run_len); else off_runs.push_back(run_len);
          run_val = field_en; run_len = 1;
        end
      end else if (prev_busy) begin
        if (run_val) on_runs.push_back(run_len); else off_runs.push_back(run_len);
        evaluate();
      end
      prev_busy = busy;
    end
  end

  task automatic wait_idle();
    while (busy || done) @(negedge clk);
  endtask

  task automatic write(input logic [31:0] d, input logic [2:0] b);
    @(negedge clk);
    data = d; block = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R7", busy == 1'b1, "busy after start", busy, 1);
    wait_idle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", {field_en, busy, done} == 3'b000, "reset outputs",
          int'({field_en, busy, done}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", {field_en, busy, done} == 3'b000, "idle after reset",
          int'({field_en, busy, done}), 0);

    write(32'hA5C3_0F96, 3'd5);
    write(32'h0000_0000, 3'd0);
    write(32'hFFFF_FFFF, 3'd7);

    // R9 and R7: change inputs and pulse start mid-write.
    @(negedge clk);
    data = 32'h5555_AAAA; block = 3'd2; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (40) @(negedge clk);
    data = 32'h1234_5678; block = 3'd6; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R7", busy == 1'b1, "busy kept through ignored start", busy, 1);
    repeat (100) @(negedge clk);
    data = '1; block = '1;
    wait_idle();

    // R10: start held high across done restarts at once.
    @(negedge clk);
    data = 32'h8000_0001; block = 3'd1; start = 1'b1;
    while (!done) @(negedge clk);
    data = 32'h7FFF_FFFE; block = 3'd4;
    @(negedge clk);
    start = 1'b0;
    check("R10", busy == 1'b1 && field_en == 1'b1, "back-to-back restart",
          int'({busy, field_en}), 3);
    wait_idle();
    repeat (5) @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      checks++;
      $display("FAIL R7 watchdog actual=%0d expected=%0d", cycles, 20000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule